// File: doc/BRIEF.md
# Reference Clock, Multiplier Control and Timer Clock Selection

This block runs the clocking of a small microcontroller as a set of one-cycle enable pulses against a single fast clock. One of two reference sources is chosen when the chip comes out of reset: a pulse stream from the internal oscillator, or pulses from an external clock pin. The instruction-cycle enable is that reference divided by two. An optional halving of the reference feeds the frequency multiplier and the comparator's digital filter. The multiplier itself lies outside the block. Its ×32 output comes in as a pulse stream, and a behavioural lock timer, counted on multiplier-reference pulses, decides when that output may be used.

A post-divider turns the multiplier output into a timer clock at divide-by-8, 4, 2 or 1. A fast-instruction mode moves the instruction enable onto the multiplier's divide-by-8 rate. The timer clock enable comes either from the instruction enable or from the post-divided multiplier output. Both the instruction source and the timer source change only in a cycle where neither the old enable nor the new enable pulses.

Two small registers control the block. Writes to the multiplier-enable bit and to the timer-source bit are dropped under the protection rules below.

Top module: `clkctl_top`

## Requirements
- R1: The reference source is captured from `boot_ext_clk` while `rst_n` is low and is then held: 0 selects `osc_tick` and 1 selects `pin_tick`.
- R2: `osc_enable` is 1 exactly when `halt` is 0 and the internal oscillator is the captured source.
- R3: While the instruction source is the reference, `icyc_en` pulses on every second selected reference pulse, giving half the reference rate.
- R4: `pll_ref_en` equals the selected reference pulse stream when register 0 bit 0 (reference halving) is 0, and half that rate when it is 1.
- R5: Once register 1 bit 0 (multiplier enable) is 1, `pll_locked` rises in the cycle after the `LOCK_TICKS`-th `pll_ref_en` pulse. It returns to 0 one cycle after the enable reads 0. It is visible as register 1 bit 7 and cannot be written.
- R6: No enable derived from the multiplier reaches `icyc_en` or `pwm_clk_en` while `pll_locked` is 0.
- R7: Register 1 bits 3:2 set the post-divider applied to `pll_tick`: 00 divides by 8, 01 by 4, 10 by 2 and 11 by 1.
- R8: With register 0 bit 1 (fast instruction mode) at 1 and the multiplier locked, `icyc_en` pulses once every 8 `pll_tick` pulses, whatever the setting of bits 3:2.
- R9: A write to register 1 while `pwm_running` is 1 leaves the multiplier-enable bit unchanged.
- R10: A write to register 1 leaves bit 1 (timer source) unchanged if `pwm_running` is 1, or if the write sets bit 1 while the multiplier-enable bit held before the write is 0.
- R11: `pwm_clk_en` follows the post-divided multiplier output when bit 1 of register 1 is 1 and the multiplier is locked. Otherwise it follows `icyc_en`.
- R12: The instruction source and the timer source each change only after a cycle in which both the old enable and the new enable are 0.
- R13: Register 0 holds reference halving in bit 0 and fast instruction mode in bit 1. Register 1 holds the multiplier enable in bit 0, the timer source in bit 1, the post-divide code in bits 3:2 and the lock flag in bit 7. All other bits read 0, and reads are combinational on `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that all enables are timed against |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_ext_clk | input | 1 | Source choice captured during reset (1 = external pin) |
| osc_tick | input | 1 | Internal oscillator pulse |
| pin_tick | input | 1 | External clock pin pulse |
| pll_tick | input | 1 | Pulse from the ×32 multiplier output |
| halt | input | 1 | Halt mode, which stops the oscillator |
| pwm_running | input | 1 | Timer run state, used for write protection |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write register select |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read register select |
| rd_data | output | 8 | Read data |
| osc_enable | output | 1 | Run request to the internal oscillator |
| pll_ref_en | output | 1 | Multiplier reference and filter clock enable |
| icyc_en | output | 1 | Instruction-cycle enable |
| pwm_clk_en | output | 1 | Timer clock enable |
| pll_locked | output | 1 | Lock flag |

## Verification
Two actions can fall in one cycle: a request to change source, and a pulse on the old or the new enable. The bench provokes this by switching fast instruction mode and the timer source on and off with `pll_tick` high every cycle and reference pulses every second cycle, so that requests keep arriving next to pulses. A reference model in the bench holds each request back until a cycle in which neither enable pulses, and it is compared with the ports on every clock. A switch one cycle early or late appears as a pulse that is missing or extra.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   localparam logic ADDR_MODE = 1'b0;
   localparam logic ADDR_PLL  = 1'b1;

   localparam int BIT_REF_HALF = 0;
   localparam int BIT_FAST     = 1;
   localparam int BIT_PLL_ON   = 0;
   localparam int BIT_PWM_PLL  = 1;
   localparam int FS_LSB       = 2;

   typedef enum logic {
      SRC_BASE = 1'b0,
      SRC_ALT  = 1'b1
   } src_e;

endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
   import clkctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int FS_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_addr_i,
   input  logic              pwm_run_i,
   input  logic              locked_i,
   output logic              ref_half_o,
   output logic              fast_icyc_o,
   output logic              pll_on_o,
   output logic              pwm_pll_o,
   output logic [FS_W-1:0]   fs_o,
   output logic [DATA_W-1:0] rd_data_o
);

   localparam int FS_MSB = FS_LSB + FS_W - 1;

   logic            ref_half_q, fast_q, pll_on_q, pwm_pll_q;
   logic [FS_W-1:0] fs_q;
   logic            unused_hi_bits;

   assign unused_hi_bits = ^wr_data_i[DATA_W-1:FS_MSB+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_half_q <= 1'b0;
         fast_q     <= 1'b0;
         pll_on_q   <= 1'b0;
         pwm_pll_q  <= 1'b0;
         fs_q       <= '0;
      end else if (wr_en_i) begin
         if (wr_addr_i == ADDR_MODE) begin
            ref_half_q <= wr_data_i[BIT_REF_HALF];
            fast_q     <= wr_data_i[BIT_FAST];
         end else begin
            fs_q <= wr_data_i[FS_MSB:FS_LSB];
            if (!pwm_run_i) begin
               pll_on_q <= wr_data_i[BIT_PLL_ON];
               if (!(wr_data_i[BIT_PWM_PLL] && !pll_on_q))
                  pwm_pll_q <= wr_data_i[BIT_PWM_PLL];
            end
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == ADDR_MODE) begin
         rd_data_o[BIT_REF_HALF] = ref_half_q;
         rd_data_o[BIT_FAST]     = fast_q;
      end else begin
         rd_data_o[BIT_PLL_ON]    = pll_on_q;
         rd_data_o[BIT_PWM_PLL]   = pwm_pll_q;
         rd_data_o[FS_MSB:FS_LSB] = fs_q;
         rd_data_o[DATA_W-1]      = locked_i;
      end
   end

   assign ref_half_o  = ref_half_q;
   assign fast_icyc_o = fast_q;
   assign pll_on_o    = pll_on_q;
   assign pwm_pll_o   = pwm_pll_q;
   assign fs_o        = fs_q;

   // Run state freezes the multiplier enable.
   assert_pll_on_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_run_i |=> (pll_on_q == $past(pll_on_q)));

   // Timer source cannot be set while the multiplier is off, nor moved while running.
   assert_pwm_sel_needs_pll_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!pll_on_q && !pwm_pll_q) |=> !pwm_pll_q);
   assert_pwm_sel_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_run_i |=> (pwm_pll_q == $past(pwm_pll_q)));

endmodule

// File: rtl/clkctl_lock.sv
module clkctl_lock #(
   parameter int LOCK_TICKS = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic ref_tick_i,
   output logic locked_o
);

   localparam int              LOCK_W = $clog2(LOCK_TICKS);
   localparam logic [LOCK_W-1:0] LAST = LOCK_W'(LOCK_TICKS - 1);

   logic [LOCK_W-1:0] cnt_q;
   logic              locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         locked_q <= 1'b0;
      end else if (!en_i) begin
         cnt_q    <= '0;
         locked_q <= 1'b0;
      end else if (!locked_q && ref_tick_i) begin
         if (cnt_q == LAST) begin
            locked_q <= 1'b1;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign locked_o = locked_q;

   assert_lock_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !locked_q);
   assert_lock_on_ref_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> ($past(ref_tick_i) && $past(en_i)));

endmodule

// File: rtl/clkctl_postdiv.sv
module clkctl_postdiv #(
   parameter int FS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            locked_i,
   input  logic            pll_tick_i,
   input  logic [FS_W-1:0] fs_i,
   output logic            pwm_tick_o,
   output logic            fast_tick_o
);

   localparam int DIV_W = (1 << FS_W) - 1;

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] mask;
   logic             live;

   assign live = pll_tick_i && locked_i;
   assign mask = (DIV_W'(1) << (DIV_W - int'(fs_i))) - DIV_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!locked_i)
         cnt_q <= '0;
      else if (pll_tick_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign pwm_tick_o  = live && ((cnt_q & mask) == mask);
   assign fast_tick_o = live && (cnt_q == {DIV_W{1'b1}});

   // The slowest rate never pulses twice in a row.
   assert_fast_spaced_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fast_tick_o |=> !fast_tick_o);

endmodule

// File: rtl/clkctl_srcsel.sv
module clkctl_srcsel
   import clkctl_pkg::*;
#(
   parameter bit GUARD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic base_tick_i,
   input  logic alt_tick_i,
   output logic tick_o
);

   src_e sel_q;
   src_e want;

   assign want = req_i ? SRC_ALT : SRC_BASE;

   generate
      if (GUARD) begin : g_guarded
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sel_q <= SRC_BASE;
            else if (want != sel_q && !base_tick_i && !alt_tick_i)
               sel_q <= want;
         end

         assert_quiet_switch_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_q != $past(sel_q)) |-> (!$past(base_tick_i) && !$past(alt_tick_i)));
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sel_q <= SRC_BASE;
            else
               sel_q <= want;
         end
      end
   endgenerate

   assign tick_o = (sel_q == SRC_ALT) ? alt_tick_i : base_tick_i;

endmodule

// File: rtl/clkctl_top.sv
module clkctl_top #(
   parameter int DATA_W     = 8,
   parameter int FS_W       = 2,
   parameter int LOCK_TICKS = 16,
   parameter bit SRC_GUARD  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_ext_clk,
   input  logic              osc_tick,
   input  logic              pin_tick,
   input  logic              pll_tick,
   input  logic              halt,
   input  logic              pwm_running,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              osc_enable,
   output logic              pll_ref_en,
   output logic              icyc_en,
   output logic              pwm_clk_en,
   output logic              pll_locked
);

   generate
      if (FS_W < 1 || FS_W > 3) begin : g_bad_fs
         $error("clkctl_top: FS_W must be 1..3");
      end
      if (DATA_W < FS_W + 3) begin : g_bad_data
         $error("clkctl_top: DATA_W too narrow for the register layout");
      end
      if (LOCK_TICKS < 2) begin : g_bad_lock
         $error("clkctl_top: LOCK_TICKS must be at least 2");
      end
   endgenerate

   logic            ext_sel_q, phase_q;
   logic            ref_tick, half_tick;
   logic            ref_half, fast_icyc, pll_on, pwm_pll;
   logic [FS_W-1:0] fs;
   logic            pwm_pll_tick, fast_tick;

   // Source choice follows the boot pin for as long as reset is held.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_sel_q <= boot_ext_clk;
         phase_q   <= 1'b0;
      end else if (ref_tick) begin
         phase_q <= ~phase_q;
      end
   end

   assign ref_tick   = ext_sel_q ? pin_tick : osc_tick;
   assign half_tick  = ref_tick && phase_q;
   assign pll_ref_en = ref_half ? half_tick : ref_tick;
   assign osc_enable = !halt && !ext_sel_q;

   clkctl_regs #(.DATA_W(DATA_W), .FS_W(FS_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (wr_en),
      .wr_addr_i   (wr_addr),
      .wr_data_i   (wr_data),
      .rd_addr_i   (rd_addr),
      .pwm_run_i   (pwm_running),
      .locked_i    (pll_locked),
      .ref_half_o  (ref_half),
      .fast_icyc_o (fast_icyc),
      .pll_on_o    (pll_on),
      .pwm_pll_o   (pwm_pll),
      .fs_o        (fs),
      .rd_data_o   (rd_data)
   );

   clkctl_lock #(.LOCK_TICKS(LOCK_TICKS)) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (pll_on),
      .ref_tick_i (pll_ref_en),
      .locked_o   (pll_locked)
   );

   clkctl_postdiv #(.FS_W(FS_W)) u_postdiv (
      .clk         (clk),
      .rst_n       (rst_n),
      .locked_i    (pll_locked),
      .pll_tick_i  (pll_tick),
      .fs_i        (fs),
      .pwm_tick_o  (pwm_pll_tick),
      .fast_tick_o (fast_tick)
   );

   clkctl_srcsel #(.GUARD(SRC_GUARD)) u_icyc_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (fast_icyc && pll_locked),
      .base_tick_i (half_tick),
      .alt_tick_i  (fast_tick),
      .tick_o      (icyc_en)
   );

   clkctl_srcsel #(.GUARD(SRC_GUARD)) u_pwm_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (pwm_pll && pll_locked),
      .base_tick_i (icyc_en),
      .alt_tick_i  (pwm_pll_tick),
      .tick_o      (pwm_clk_en)
   );

   // Nothing derived from the multiplier leaves the block before lock.
   assert_no_early_pll_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pll_locked && !ref_tick) |-> (!icyc_en && !pwm_clk_en));

endmodule

// File: tb/clkctl_top_bench.sv
`timescale 1ns/1ps
module clkctl_top_bench;

   localparam int LOCK = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boot_ext_clk = 1'b0;
   logic       osc_tick = 1'b0, pin_tick = 1'b0, pll_tick = 1'b0;
   logic       halt = 1'b0, pwm_running = 1'b0;
   logic       wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b1;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       osc_enable, pll_ref_en, icyc_en, pwm_clk_en, pll_locked;

   always #2.5 clk = ~clk;

   clkctl_top u_clkctl_top (
      .clk(clk), .rst_n(rst_n), .boot_ext_clk(boot_ext_clk),
      .osc_tick(osc_tick), .pin_tick(pin_tick), .pll_tick(pll_tick),
      .halt(halt), .pwm_running(pwm_running),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .osc_enable(osc_enable), .pll_ref_en(pll_ref_en), .icyc_en(icyc_en),
      .pwm_clk_en(pwm_clk_en), .pll_locked(pll_locked)
   );

   int n_vec = 0, n_bad = 0, cyc = 0, wd = 0;
   int osc_per = 4, pin_per = 0, pll_per = 1;
   int cnt_icyc = 0, cnt_pwm = 0, cnt_pref = 0;

   // reference model state
   int m_ext, m_par, m_refhalf, m_fmode, m_pllen, m_fsel, m_fs;
   int m_lc, m_locked, m_pcnt, m_isel, m_psel;
   int m_ref, m_half, m_pref, m_pt, m_mask, m_pwmpll, m_fast, m_icyc, m_pwm, m_rd;

   task automatic check(string req, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic model_reset();
      m_ext = boot_ext_clk; m_par = 0; m_refhalf = 0; m_fmode = 0; m_pllen = 0;
      m_fsel = 0; m_fs = 0; m_lc = 0; m_locked = 0; m_pcnt = 0; m_isel = 0; m_psel = 0;
   endtask

   task automatic model_eval();
      m_ref    = m_ext ? int'(pin_tick) : int'(osc_tick);
      m_half   = m_ref & m_par;
      m_pref   = m_refhalf ? m_half : m_ref;
      m_pt     = int'(pll_tick) & m_locked;
      m_mask   = (1 << (3 - m_fs)) - 1;
      m_pwmpll = (m_pt != 0 && (m_pcnt & m_mask) == m_mask) ? 1 : 0;
      m_fast   = (m_pt != 0 && m_pcnt == 7) ? 1 : 0;
      m_icyc   = m_isel ? m_fast : m_half;
      m_pwm    = m_psel ? m_pwmpll : m_icyc;
      m_rd     = rd_addr ? ((m_locked << 7) | (m_fs << 2) | (m_fsel << 1) | m_pllen)
                         : ((m_fmode << 1) | m_refhalf);
   endtask

   task automatic model_step();
      int ireq, preq, old_en;
      ireq = m_fmode & m_locked;
      preq = m_fsel & m_locked;
      if (ireq != m_isel && m_half == 0 && m_fast == 0) m_isel = ireq;
      if (preq != m_psel && m_icyc == 0 && m_pwmpll == 0) m_psel = preq;
      if (m_locked == 0) m_pcnt = 0;
      else if (pll_tick) m_pcnt = (m_pcnt + 1) % 8;
      if (m_pllen == 0) begin
         m_lc = 0; m_locked = 0;
      end else if (m_locked == 0 && m_pref != 0) begin
         if (m_lc == LOCK - 1) begin m_locked = 1; m_lc = 0; end
         else m_lc++;
      end
      m_par ^= m_ref;
      old_en = m_pllen;
      if (wr_en) begin
         if (wr_addr == 1'b0) begin
            m_refhalf = wr_data[0]; m_fmode = wr_data[1];
         end else begin
            m_fs = wr_data[3:2];
            if (!pwm_running) begin
               m_pllen = wr_data[0];
               if (!(wr_data[1] && old_en == 0)) m_fsel = wr_data[1];
            end
         end
      end
   endtask

   // One cycle: drive after the falling edge, compare, then cross the rising edge.
   task automatic step();
      osc_tick = (osc_per != 0) && (cyc % osc_per == 0);
      pin_tick = (pin_per != 0) && (cyc % pin_per == 0);
      pll_tick = (pll_per != 0) && (cyc % pll_per == 0);
      #1;
      model_eval();
      check("R2", "osc_enable", int'(osc_enable), m_ext == 0 && !halt ? 1 : 0);
      check("R4", "pll_ref_en", int'(pll_ref_en), m_pref);
      check("R5", "pll_locked", int'(pll_locked), m_locked);
      check("R3/R8/R12", "icyc_en", int'(icyc_en), m_icyc);
      check("R11/R7/R12", "pwm_clk_en", int'(pwm_clk_en), m_pwm);
      check("R13", "rd_data", int'(rd_data), m_rd);
      cnt_icyc += int'(icyc_en);
      cnt_pwm  += int'(pwm_clk_en);
      cnt_pref += int'(pll_ref_en);
      model_step();
      @(posedge clk);
      @(negedge clk);
      cyc++;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic write_reg(logic a, logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic counted(int n);
      cnt_icyc = 0; cnt_pwm = 0; cnt_pref = 0;
      run(n);
   endtask

   task automatic do_reset(logic ext);
      rst_n = 1'b0; boot_ext_clk = ext;
      repeat (3) @(negedge clk);
      model_reset();
      boot_ext_clk = ~ext;   // pin moves after reset: must not matter (R1)
      rst_n = 1'b1;
      cyc = 0;
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_bad++;
         $display("FAIL watchdog: actual=%0d cycles expected=<150000", wd);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      do_reset(1'b0);
      #1;
      check("R13", "reset rd_data", int'(rd_data), 0);
      check("R2", "reset osc_enable", int'(osc_enable), 1);
      check("R5", "reset pll_locked", int'(pll_locked), 0);

      osc_per = 4; pll_per = 1;
      run(16);
      counted(80);
      check("R3", "icyc pulses in 80 cycles, ref every 4", cnt_icyc, 10);

      write_reg(1'b0, 8'h01);
      counted(80);
      check("R4", "pll_ref pulses in 80 cycles, halved", cnt_pref, 10);

      write_reg(1'b1, 8'h02);   // set timer source with multiplier off
      rd_addr = 1'b1; #1;
      check("R10", "timer source after refused set", int'(rd_data[1]), 0);

      osc_per = 2;
      write_reg(1'b0, 8'h03);   // fast mode requested before lock
      write_reg(1'b1, 8'h01);
      counted(48);
      check("R6", "icyc pulses while unlocked", cnt_icyc, 12);
      check("R5", "still unlocked after 48 cycles", int'(pll_locked), 0);
      run(60);
      check("R5", "locked after lock time", int'(pll_locked), 1);
      rd_addr = 1'b1; #1;
      check("R5", "lock flag in bit 7", int'(rd_data[7]), 1);

      write_reg(1'b1, 8'h03);
      rd_addr = 1'b1; #1;
      check("R10", "timer source accepted with multiplier on", int'(rd_data[1]), 1);
      for (int f = 0; f < 4; f++) begin
         write_reg(1'b1, 8'(8'h03 | (f << 2)));
         run(4);
         counted(64);
         check("R7", $sformatf("timer pulses per 64 with code %0d", f), cnt_pwm, 64 >> (3 - f));
      end

      pwm_running = 1'b1;
      write_reg(1'b1, 8'h00);
      rd_addr = 1'b1; #1;
      check("R9", "multiplier enable kept while running", int'(rd_data[0]), 1);
      check("R10", "timer source kept while running", int'(rd_data[1]), 1);
      check("R13", "register 1 after protected write", int'(rd_data), 8'h83);
      pwm_running = 1'b0;

      counted(64);
      check("R8", "fast icyc pulses per 64, code 0", cnt_icyc, 8);
      write_reg(1'b1, 8'h0F);
      run(4);
      counted(64);
      check("R8", "fast icyc pulses per 64, code 3", cnt_icyc, 8);

      for (int k = 0; k < 12; k++) begin   // switch requests next to pulses (R12)
         write_reg(1'b0, (k % 2) ? 8'h03 : 8'h01);
         run(3 + k % 5);
         write_reg(1'b1, (k % 3 == 0) ? 8'h09 : 8'h0B);
         run(2 + k % 4);
      end

      pll_per = 3;
      run(100);

      halt = 1'b1; #1;
      check("R2", "oscillator stopped in halt", int'(osc_enable), 0);
      run(10);
      halt = 1'b0;

      write_reg(1'b1, 8'h00);
      run(2);
      check("R5", "lock cleared with enable off", int'(pll_locked), 0);
      run(40);

      do_reset(1'b1);
      osc_per = 3; pin_per = 6; pll_per = 1;
      #1;
      check("R1", "oscillator off with external source", int'(osc_enable), 0);
      run(12);
      counted(120);
      check("R1", "icyc follows pin pulses", cnt_icyc, 10);
      check("R11", "timer follows icyc without multiplier", cnt_pwm, 10);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule